// File: doc/BRIEF.md
# Nim Game Engine with Built-in Opponent

This block plays Nim between a person and an automatic opponent. It keeps three stacks of items and a record of whose turn it is. On the opponent's turn the engine moves by itself on the next clock edge and uses the nim-sum strategy. On the person's turn it waits for a move strobe. It then checks the requested move and applies it or rejects it. When every stack reaches zero the game is over. The player who took the last item is flagged as the winner, and the engine then freezes until the next reset.

The human move is given by three plain control pins: a one-cycle-qualified strobe, a one-hot stack select and a remove count. There is no back-pressure and no handshake. A move is taken when the strobe is high at a clock edge during the human turn, and it is either applied or flagged as rejected in that same cycle. The stack sizes, the rejection flag and the two winner flags are plain status outputs.

Top module: `nim_engine`

## Requirements
- R1: A synchronous reset loads the stacks with A=3, B=4, C=5 (parameters), gives the first turn to the opponent and leaves the rejection flag and both winner flags low.
- R2: In the cycle after its turn begins, the opponent moves with no strobe. It computes X = A^B^C and sets the first stack, checked in A, B, C order, whose value XOR X is strictly smaller than the stack, to that value. Its move ignores the human inputs.
- R3: When no such stack exists (X is zero), the opponent removes exactly one item from the first non-empty stack, checked in A, B, C order.
- R4: The stack select is one-hot: 3'b001 selects A, 3'b010 selects B, 3'b100 selects C. Any other code, including 0, makes a strobed human move invalid.
- R5: A strobed human move with a valid select and a count n where 1 <= n <= selected size reduces that stack by n on the clock edge and passes the turn to the opponent.
- R6: The rejection flag is high only when the move strobe is high during the human turn of an unfinished game and the move fails validation (bad select, zero count, or count above the stack size). A rejected move leaves every stack unchanged and the turn stays with the human.
- R7: While the strobe is low during the human turn, the stacks do not change and the rejection flag stays low.
- R8: Each accepted move changes exactly one stack, no stack ever grows outside reset, and turns alternate after each accepted move.
- R9: When all three stacks are zero, the flag of the player who made the last move is high and the other is low. No winner flag is high before that.
- R10: After a winner is flagged, all inputs are ignored. The stacks and winner flags hold and the rejection flag stays low until reset.
- R11: Reset asserted in the middle of a game restores the R1 state on the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| move_en | input | 1 | Human move strobe |
| pick_sel | input | 3 | One-hot stack select (001 A, 010 B, 100 C) |
| take_cnt | input | 4 | Number of items to remove |
| size_a | output | 4 | Current size of stack A |
| size_b | output | 4 | Current size of stack B |
| size_c | output | 4 | Current size of stack C |
| bad_move | output | 1 | Strobed human move rejected this cycle |
| human_won | output | 1 | Game over, the person took the last item |
| machine_won | output | 1 | Game over, the opponent took the last item |

## Verification
Two pairs of functions can fall in the same cycle. The first is the opponent's automatic move and a human strobe carrying an illegal select. The bench holds the strobe high with code 3'b111 exactly on the opponent's cycle, and it expects the strategy move to land with the rejection flag low. The second is end-of-game detection and move validation. On the cycle right after the final item is taken, the bench drives a move that would otherwise be legal or illegal. It then judges that the stacks, the winner flags and the low rejection flag all hold. A swept sequence of strobe, select and count codes over many games compares every cycle against an arithmetic model of the rules.

// File: rtl/nim_pkg.sv
package nim_pkg;
  // number of stacks; select is one-hot over this many bits
  localparam int NSTK = 3;

  typedef enum logic {
    SIDE_MACHINE = 1'b0,
    SIDE_HUMAN   = 1'b1
  } side_e;
endpackage

// File: rtl/nim_strategy.sv
module nim_strategy
  import nim_pkg::*;
#(
  parameter int W = 4
) (
  input  logic [NSTK-1:0][W-1:0] heaps,
  output logic [NSTK-1:0]        pick,
  output logic [W-1:0]           new_size
);
  logic [W-1:0] nsum;
  logic         found;

  always_comb begin
    nsum = '0;
    for (int i = 0; i < NSTK; i++) nsum = nsum ^ heaps[i];

    pick     = '0;
    new_size = '0;
    found    = 1'b0;
    // winning reduction, lowest stack first
    for (int i = 0; i < NSTK; i++) begin
      if (!found && ((heaps[i] ^ nsum) < heaps[i])) begin
        pick[i]  = 1'b1;
        new_size = heaps[i] ^ nsum;
        found    = 1'b1;
      end
    end
    // stall: one item from the first non-empty stack
    for (int i = 0; i < NSTK; i++) begin
      if (!found && (heaps[i] != '0)) begin
        pick[i]  = 1'b1;
        new_size = heaps[i] - W'(1);
        found    = 1'b1;
      end
    end
  end
endmodule

// File: rtl/nim_validate.sv
module nim_validate
  import nim_pkg::*;
#(
  parameter int W = 4
) (
  input  logic [NSTK-1:0][W-1:0] heaps,
  input  logic [NSTK-1:0]        sel,
  input  logic [W-1:0]           cnt,
  output logic                   legal,
  output logic [W-1:0]           new_size
);
  logic         sel_ok;
  logic [W-1:0] chosen;

  always_comb begin
    sel_ok = (sel != '0) && ((sel & (sel - NSTK'(1))) == '0);
    chosen = '0;
    for (int i = 0; i < NSTK; i++) begin
      if (sel[i]) chosen = chosen | heaps[i];
    end
    legal    = sel_ok && (cnt != '0) && (cnt <= chosen);
    new_size = chosen - cnt;
  end
endmodule

// File: rtl/nim_state.sv
module nim_state
  import nim_pkg::*;
#(
  parameter int                          W    = 4,
  parameter logic [NSTK-1:0][W-1:0]      INIT = '0
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   freeze,
  input  logic [NSTK-1:0]        ai_pick,
  input  logic [W-1:0]           ai_size,
  input  logic                   hu_take,
  input  logic [NSTK-1:0]        hu_pick,
  input  logic [W-1:0]           hu_size,
  output logic [NSTK-1:0][W-1:0] heaps,
  output side_e                  turn
);
  for (genvar g = 0; g < NSTK; g++) begin : g_stack
    logic [W-1:0] q;
    always_ff @(posedge clk) begin
      if (rst) begin
        q <= INIT[g];
      end else if (!freeze) begin
        if (turn == SIDE_MACHINE && ai_pick[g]) begin
          q <= ai_size;
        end else if (turn == SIDE_HUMAN && hu_take && hu_pick[g]) begin
          q <= hu_size;
        end
      end
    end
    assign heaps[g] = q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      turn <= SIDE_MACHINE;
    end else if (!freeze) begin
      if (turn == SIDE_MACHINE) turn <= SIDE_HUMAN;
      else if (hu_take)         turn <= SIDE_MACHINE;
    end
  end
endmodule

// File: rtl/nim_engine.sv
module nim_engine
  import nim_pkg::*;
#(
  parameter int W      = 4,
  parameter int INIT_A = 3,
  parameter int INIT_B = 4,
  parameter int INIT_C = 5
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         move_en,
  input  logic [2:0]   pick_sel,
  input  logic [W-1:0] take_cnt,
  output logic [W-1:0] size_a,
  output logic [W-1:0] size_b,
  output logic [W-1:0] size_c,
  output logic         bad_move,
  output logic         human_won,
  output logic         machine_won
);
  localparam logic [NSTK-1:0][W-1:0] INIT_VEC =
    {W'(INIT_C), W'(INIT_B), W'(INIT_A)};

  logic [NSTK-1:0][W-1:0] heaps;
  logic [NSTK-1:0]        ai_pick;
  logic [W-1:0]           ai_size;
  logic                   hu_legal;
  logic [W-1:0]           hu_size;
  logic                   game_over;
  logic                   hu_take;
  side_e                  turn;

  nim_strategy #(.W(W)) u_strat (
    .heaps    (heaps),
    .pick     (ai_pick),
    .new_size (ai_size)
  );

  nim_validate #(.W(W)) u_valid (
    .heaps    (heaps),
    .sel      (pick_sel),
    .cnt      (take_cnt),
    .legal    (hu_legal),
    .new_size (hu_size)
  );

  assign game_over = (heaps == '0);
  assign hu_take   = move_en && hu_legal;

  nim_state #(.W(W), .INIT(INIT_VEC)) u_state (
    .clk     (clk),
    .rst     (rst),
    .freeze  (game_over),
    .ai_pick (ai_pick),
    .ai_size (ai_size),
    .hu_take (hu_take),
    .hu_pick (pick_sel),
    .hu_size (hu_size),
    .heaps   (heaps),
    .turn    (turn)
  );

  assign size_a      = heaps[0];
  assign size_b      = heaps[1];
  assign size_c      = heaps[2];
  // the side holding the turn at the end did not take the last item
  assign human_won   = game_over && (turn == SIDE_MACHINE);
  assign machine_won = game_over && (turn == SIDE_HUMAN);
  assign bad_move    = (turn == SIDE_HUMAN) && !game_over && move_en && !hu_legal;
endmodule

// File: rtl/nim_engine_chk.sv
module nim_engine_chk #(
  parameter int W = 4
) (
  input logic         clk,
  input logic         rst,
  input logic         move_en,
  input logic [W-1:0] size_a,
  input logic [W-1:0] size_b,
  input logic [W-1:0] size_c,
  input logic         bad_move,
  input logic         human_won,
  input logic         machine_won
);
  // R8
  one_stack_step_chk: assert property (@(posedge clk) disable iff (rst)
    !rst |=> ($countones({size_a != $past(size_a), size_b != $past(size_b),
                          size_c != $past(size_c)}) <= 1));

  // R8
  no_growth_chk: assert property (@(posedge clk) disable iff (rst)
    !rst |=> (size_a <= $past(size_a)) && (size_b <= $past(size_b))
             && (size_c <= $past(size_c)));

  // R6
  reject_hold_chk: assert property (@(posedge clk) disable iff (rst)
    bad_move |=> $stable(size_a) && $stable(size_b) && $stable(size_c));

  // R6
  reject_needs_strobe_chk: assert property (@(posedge clk) disable iff (rst)
    bad_move |-> move_en && !human_won && !machine_won);

  // R9
  single_winner_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0({human_won, machine_won}));

  // R9
  win_means_empty_chk: assert property (@(posedge clk) disable iff (rst)
    (human_won || machine_won) |-> (size_a == '0) && (size_b == '0) && (size_c == '0));

  // R10
  end_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (human_won || machine_won) |=> $stable(size_a) && $stable(size_b) && $stable(size_c)
                                   && $stable(human_won) && $stable(machine_won));
endmodule

bind nim_engine nim_engine_chk #(.W(W)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .move_en     (move_en),
  .size_a      (size_a),
  .size_b      (size_b),
  .size_c      (size_c),
  .bad_move    (bad_move),
  .human_won   (human_won),
  .machine_won (machine_won)
);

// File: tb/sim_nim_engine.sv
module sim_nim_engine;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       move_en = 1'b0;
  logic [2:0] pick_sel = 3'b000;
  logic [3:0] take_cnt = 4'd0;
  logic [3:0] size_a, size_b, size_c;
  logic       bad_move, human_won, machine_won;

  logic       x_en = 1'b0;
  logic [2:0] x_sel = 3'b000;
  logic [3:0] x_cnt = 4'd0;
  logic [3:0] x_a, x_b, x_c;
  logic       x_bad, x_hw, x_mw;

  int n_chk = 0;
  int n_bad = 0;
  int m[3];
  bit mh;   // 1: human to move in the model

  always #10 clk = ~clk;

  nim_engine u0 (
    .clk(clk), .rst(rst), .move_en(move_en), .pick_sel(pick_sel), .take_cnt(take_cnt),
    .size_a(size_a), .size_b(size_b), .size_c(size_c),
    .bad_move(bad_move), .human_won(human_won), .machine_won(machine_won)
  );

  // second engine started from a zero nim-sum position (1,2,3)
  nim_engine #(.INIT_A(1), .INIT_B(2), .INIT_C(3)) u1 (
    .clk(clk), .rst(rst), .move_en(x_en), .pick_sel(x_sel), .take_cnt(x_cnt),
    .size_a(x_a), .size_b(x_b), .size_c(x_c),
    .bad_move(x_bad), .human_won(x_hw), .machine_won(x_mw)
  );

  task automatic check(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic bit m_over();
    return (m[0] == 0) && (m[1] == 0) && (m[2] == 0);
  endfunction

  function automatic int sel_index(input logic [2:0] sel);
    case (sel)
      3'b001:  return 0;
      3'b010:  return 1;
      3'b100:  return 2;
      default: return -1;
    endcase
  endfunction

  // opponent rule from the requirements; returns 1 when it stalled
  function automatic bit m_ai();
    int x;
    x = m[0] ^ m[1] ^ m[2];
    for (int i = 0; i < 3; i++) begin
      if ((m[i] ^ x) < m[i]) begin
        m[i] = m[i] ^ x;
        return 1'b0;
      end
    end
    for (int i = 0; i < 3; i++) begin
      if (m[i] != 0) begin
        m[i] = m[i] - 1;
        return 1'b1;
      end
    end
    return 1'b1;
  endfunction

  task automatic check_state(input string tag);
    bit ov;
    ov = m_over();
    check({tag, " size_a"}, int'(size_a), m[0]);
    check({tag, " size_b"}, int'(size_b), m[1]);
    check({tag, " size_c"}, int'(size_c), m[2]);
    check({tag, " human_won"}, int'(human_won), int'(ov && !mh));
    check({tag, " machine_won"}, int'(machine_won), int'(ov && mh));
  endtask

  task automatic do_reset(input string tag);
    rst = 1'b1;
    @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    m[0] = 3; m[1] = 4; m[2] = 5; mh = 1'b0;
    check_state(tag);
    check({tag, " bad_move"}, int'(bad_move), 0);
  endtask

  // one cycle on u0, starting and ending at a falling edge
  task automatic step(input logic en, input logic [2:0] sel, input logic [3:0] cnt);
    bit ov, ok, stall;
    int idx;
    string tag;
    move_en = en; pick_sel = sel; take_cnt = cnt;
    #1;
    ov  = m_over();
    idx = sel_index(sel);
    ok  = (idx >= 0) && (cnt != 0) && (int'(cnt) <= m[(idx < 0) ? 0 : idx]);
    if (ov)            tag = "R10";
    else if (!mh)      tag = "R2";
    else if (!en)      tag = "R7";
    else if (ok)       tag = "R5";
    else if (idx < 0)  tag = "R4";
    else               tag = "R6";
    check({tag, " bad_move"}, int'(bad_move), int'(mh && !ov && en && !ok));
    if (!ov) begin
      if (!mh) begin
        stall = m_ai();
        if (stall) tag = "R3";
        mh = 1'b1;
      end else if (en && ok) begin
        m[idx] = m[idx] - int'(cnt);
        mh = 1'b0;
      end
    end
    @(posedge clk);
    @(negedge clk);
    check_state(tag);
  endtask

  // one cycle on u1 with literal expected values
  task automatic step1(input string tag, input logic en, input logic [2:0] sel,
                       input logic [3:0] cnt, input int ea, input int eb, input int ec,
                       input int ehw, input int emw);
    x_en = en; x_sel = sel; x_cnt = cnt;
    @(posedge clk);
    @(negedge clk);
    check({tag, " u1 a"}, int'(x_a), ea);
    check({tag, " u1 b"}, int'(x_b), eb);
    check({tag, " u1 c"}, int'(x_c), ec);
    check({tag, " u1 human_won"}, int'(x_hw), ehw);
    check({tag, " u1 machine_won"}, int'(x_mw), emw);
  endtask

  task automatic finish_run();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    #(20 * 150000);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: run did not end, actual=hung expected=done");
    finish_run();
  end

  initial begin
    @(negedge clk);
    // R1 reset state
    do_reset("R1");

    // R2: opponent moves while the strobe carries junk; 3,4,5 -> 1,4,5
    step(1'b1, 3'b111, 4'd0);
    check("R2 first reply a", int'(size_a), 1);
    // R5: take all of B (count equals size)
    step(1'b1, 3'b010, 4'd4);
    check("R5 b emptied", int'(size_b), 0);
    // R2 priority: x=4, only C qualifies -> 1,0,1
    step(1'b0, 3'b000, 4'd0);
    check("R2 c reduced", int'(size_c), 1);
    // R4 non one-hot select, R6 count too big, R6 zero count, R7 no strobe
    step(1'b1, 3'b011, 4'd1);
    check("R4 reject flag", int'(bad_move), 1);
    step(1'b1, 3'b001, 4'd2);
    step(1'b1, 3'b001, 4'd0);
    step(1'b0, 3'b001, 4'd1);
    // R6 turn stayed with the human: a legal move is still accepted
    step(1'b1, 3'b001, 4'd1);
    // opponent empties C -> R9 machine wins
    step(1'b0, 3'b000, 4'd0);
    check("R9 machine_won", int'(machine_won), 1);
    // R10 inputs ignored after the end
    step(1'b1, 3'b100, 4'd1);
    step(1'b1, 3'b011, 4'd0);
    check("R10 no reject after end", int'(bad_move), 0);

    // R11 reset from a finished game and then from mid-game
    do_reset("R11");
    step(1'b0, 3'b000, 4'd0);
    do_reset("R11");

    // swept games against the model
    for (int g = 0; g < 30; g++) begin
      int after;
      do_reset("R11");
      after = 0;
      for (int s = 0; s < 200; s++) begin
        int code;
        code = (s * 53 + g * 29 + 7) % 256;
        step((code % 4) != 0, 3'(code >> 4), 4'(code));
        if (m_over()) after++;
        if (after > 3) break;
      end
    end

    // u1: zero nim-sum start, opponent stalls (R3), human wins (R9)
    do_reset("R1");
    step1("R3", 1'b0, 3'b000, 4'd0, 0, 2, 3, 0, 0);
    step1("R5", 1'b1, 3'b100, 4'd1, 0, 2, 2, 0, 0);
    step1("R3", 1'b0, 3'b000, 4'd0, 0, 1, 2, 0, 0);
    step1("R5", 1'b1, 3'b100, 4'd1, 0, 1, 1, 0, 0);
    step1("R3", 1'b0, 3'b000, 4'd0, 0, 0, 1, 0, 0);
    step1("R9", 1'b1, 3'b100, 4'd1, 0, 0, 0, 1, 0);
    step1("R10", 1'b1, 3'b010, 4'd1, 0, 0, 0, 1, 0);
    check("R10 u1 reject low", int'(x_bad), 0);

    finish_run();
  end
endmodule